// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block is a pipelined signed multiply datapath for a processor execute stage. Each accepted operation reads two word operands, a 32-bit addend and a 64-bit addend split into low and high words. Two selector bits and an operation code decide what is computed. The multiplier can take a 16-bit half from each operand, or the whole first operand times a 16-bit half of the second. The product is then returned as is, added to the 32-bit addend, or added to the 64-bit addend. Register file access and instruction decode are handled elsewhere.

Operations enter on a valid/ready stream and leave on another. A transfer happens on a rising clock edge where both valid and ready are high. The output may be stalled with `out_ready` low. While it is stalled, the output words and `out_valid` hold still and the whole pipeline freezes. `in_ready` is high exactly when the output register is empty or is being drained in the same cycle. With no stall, a result appears two cycles after it is accepted. A sticky overflow flag collects signed overflow from the two 32-bit accumulate operations. It is a plain status pin with its own synchronous clear.

Top module: `smac_unit`

## Requirements
- R1: `in_sel_x` = 1 selects bits 31:16 of `in_a` as the first half-operand, and 0 selects bits 15:0. `in_sel_y` picks from `in_b` in the same way. This holds for every operation that uses a half of that operand.
- R2: Op code 0 (half multiply) treats both selected halves as signed 16-bit values. It returns the low 32 bits of their product on `out_lo`.
- R3: Op code 0 never sets the overflow flag.
- R4: Op code 1 (half multiply, 32-bit accumulate) returns product + `in_acc` modulo 2^32, without saturation. It sets the sticky flag when this addition overflows as a signed value.
- R5: Op code 3 (word-by-half multiply) forms the signed 48-bit product of `in_a` and the selected half of `in_b`. It returns bits 47:16 of that product and never sets the flag.
- R6: Op code 4 (word-by-half accumulate) adds `in_acc` to the R5 result with wraparound. It sets the sticky flag on signed overflow of that 32-bit addition.
- R7: Op code 2 (long accumulate) sign-extends the half product to 64 bits and adds it to {`in_acc_hi`,`in_acc_lo`} modulo 2^64. The carry from the low word goes into the high word. Both words appear together on `out_hi`/`out_lo`, and the flag is not affected.
- R8: For every op code other than 2, `out_hi` is 0. Op codes 5 to 7 give `out_lo` = 0 and leave the flag alone.
- R9: With `out_ready` held high, an operation accepted at a clock edge appears with `out_valid` high after the second edge that follows it. `out_valid` stays low after reset.
- R10: While `out_valid` is high and `out_ready` is low, the outputs hold and `in_ready` is low. `in_ready` is high whenever `out_valid` is low.
- R11: The sticky flag is 0 after reset. It rises at the edge where an overflowing result enters the output register. It falls only at an edge where `ovf_clr` is high, but a new overflow at that same edge wins and keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Input operation accepted when high |
| in_op | input | 3 | Operation code (0..4, 5..7 reserved) |
| in_sel_x | input | 1 | Half selector for `in_a` |
| in_sel_y | input | 1 | Half selector for `in_b` |
| in_a | input | 32 | First multiply operand |
| in_b | input | 32 | Second multiply operand |
| in_acc | input | 32 | 32-bit addend |
| in_acc_lo | input | 32 | Low word of 64-bit addend |
| in_acc_hi | input | 32 | High word of 64-bit addend |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream can take the result |
| out_lo | output | 32 | Result, low word |
| out_hi | output | 32 | Result, high word (zero for 32-bit ops) |
| ovf_clr | input | 1 | Synchronous clear of the sticky flag |
| ovf_sticky | output | 1 | Sticky signed-overflow flag |

## Verification
The bound checker watches the stream rules on every cycle. It checks that stalled outputs hold and that `in_ready` is never low while the output is empty. It also checks that an accepted operation always moves one stage per unstalled edge. For the flag, it checks that it only rises together with a valid result and only falls after a clear. The arithmetic itself can only be shown by the bench scenarios, which compare each result with a wide-integer reference model. That covers half selection, sign handling at 0x8000 and 0x80000000, the 48-bit slice, carry into the high word, and which op codes may raise the flag.

// File: rtl/smac_pkg.sv
package smac_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    SMAC_HMUL  = 3'd0,
    SMAC_HMAC  = 3'd1,
    SMAC_HMACL = 3'd2,
    SMAC_WMUL  = 3'd3,
    SMAC_WMAC  = 3'd4,
    SMAC_RSV5  = 3'd5,
    SMAC_RSV6  = 3'd6,
    SMAC_RSV7  = 3'd7
  } smac_op_e;

  function automatic logic is_word_op(smac_op_e op);
    return (op == SMAC_WMUL) || (op == SMAC_WMAC);
  endfunction

endpackage

// File: rtl/smac_half_sel.sv
module smac_half_sel #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]   word,
  input  logic            sel_hi,
  output logic [DW/2-1:0] half
);
  localparam int unsigned HW = DW / 2;

  always_comb begin
    half = sel_hi ? word[DW-1:HW] : word[HW-1:0];
  end
endmodule

// File: rtl/smac_mul_stage.sv
module smac_mul_stage
  import smac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_valid,
  input  smac_op_e      in_op,
  input  logic          in_sel_x,
  input  logic          in_sel_y,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_acc,
  input  logic [DW-1:0] in_acc_lo,
  input  logic [DW-1:0] in_acc_hi,
  output logic          s1_valid,
  output smac_op_e      s1_op,
  output logic [DW-1:0] s1_prod,
  output logic [DW-1:0] s1_acc,
  output logic [DW-1:0] s1_acc_lo,
  output logic [DW-1:0] s1_acc_hi
);
  localparam int unsigned HW = DW / 2;
  localparam int unsigned WP = DW + HW;

  logic [HW-1:0]        half_a;
  logic [HW-1:0]        half_b;
  logic signed [DW-1:0] prod_hh;
  logic signed [WP-1:0] prod_wh;
  logic [DW-1:0]        prod_sel;
  logic                 unused_wh_lsb;

  smac_half_sel #(.DW(DW)) u_sel_a (.word(in_a), .sel_hi(in_sel_x), .half(half_a));
  smac_half_sel #(.DW(DW)) u_sel_b (.word(in_b), .sel_hi(in_sel_y), .half(half_b));

  always_comb begin
    prod_hh  = $signed(half_a) * $signed(half_b);
    prod_wh  = $signed(in_a) * $signed(half_b);
    prod_sel = is_word_op(in_op) ? prod_wh[WP-1:HW] : prod_hh;
  end

  assign unused_wh_lsb = ^prod_wh[HW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_op     <= SMAC_HMUL;
      s1_prod   <= '0;
      s1_acc    <= '0;
      s1_acc_lo <= '0;
      s1_acc_hi <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op     <= in_op;
        s1_prod   <= prod_sel;
        s1_acc    <= in_acc;
        s1_acc_lo <= in_acc_lo;
        s1_acc_hi <= in_acc_hi;
      end
    end
  end
endmodule

// File: rtl/smac_acc_stage.sv
module smac_acc_stage
  import smac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          ovf_clr,
  input  logic          s1_valid,
  input  smac_op_e      s1_op,
  input  logic [DW-1:0] s1_prod,
  input  logic [DW-1:0] s1_acc,
  input  logic [DW-1:0] s1_acc_lo,
  input  logic [DW-1:0] s1_acc_hi,
  output logic          out_valid,
  output logic [DW-1:0] out_lo,
  output logic [DW-1:0] out_hi,
  output logic          ovf_sticky
);
  logic [DW-1:0] sum32;
  logic          sum32_ov;
  logic [DW:0]   lo_wide;
  logic [DW-1:0] hi_sum;
  logic [DW-1:0] nxt_lo;
  logic [DW-1:0] nxt_hi;
  logic          nxt_ov;
  logic          set_ov;

  always_comb begin
    sum32    = s1_prod + s1_acc;
    sum32_ov = (s1_prod[DW-1] == s1_acc[DW-1]) && (sum32[DW-1] != s1_prod[DW-1]);
    lo_wide  = {1'b0, s1_acc_lo} + {1'b0, s1_prod};
    hi_sum   = s1_acc_hi + {DW{s1_prod[DW-1]}} + {{(DW-1){1'b0}}, lo_wide[DW]};
    nxt_lo   = '0;
    nxt_hi   = '0;
    nxt_ov   = 1'b0;
    unique case (s1_op)
      SMAC_HMUL, SMAC_WMUL: nxt_lo = s1_prod;
      SMAC_HMAC, SMAC_WMAC: begin
        nxt_lo = sum32;
        nxt_ov = sum32_ov;
      end
      SMAC_HMACL: begin
        nxt_lo = lo_wide[DW-1:0];
        nxt_hi = hi_sum;
      end
      default: nxt_lo = '0;
    endcase
  end

  assign set_ov = adv && s1_valid && nxt_ov;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_lo     <= '0;
      out_hi     <= '0;
      ovf_sticky <= 1'b0;
    end else begin
      ovf_sticky <= (ovf_sticky && !ovf_clr) || set_ov;
      if (adv) begin
        out_valid <= s1_valid;
        if (s1_valid) begin
          out_lo <= nxt_lo;
          out_hi <= nxt_hi;
        end
      end
    end
  end
endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic          in_sel_x,
  input  logic          in_sel_y,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_acc,
  input  logic [DW-1:0] in_acc_lo,
  input  logic [DW-1:0] in_acc_hi,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_lo,
  output logic [DW-1:0] out_hi,
  input  logic          ovf_clr,
  output logic          ovf_sticky
);
  logic          adv;
  logic          s1_valid;
  smac_op_e      s1_op;
  logic [DW-1:0] s1_prod;
  logic [DW-1:0] s1_acc;
  logic [DW-1:0] s1_acc_lo;
  logic [DW-1:0] s1_acc_hi;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  smac_mul_stage #(.DW(DW)) u_mul (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
    .in_op(smac_op_e'(in_op)), .in_sel_x(in_sel_x), .in_sel_y(in_sel_y),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
    .in_acc_lo(in_acc_lo), .in_acc_hi(in_acc_hi),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_prod(s1_prod), .s1_acc(s1_acc),
    .s1_acc_lo(s1_acc_lo), .s1_acc_hi(s1_acc_hi)
  );

  smac_acc_stage #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ovf_clr(ovf_clr),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_prod(s1_prod), .s1_acc(s1_acc),
    .s1_acc_lo(s1_acc_lo), .s1_acc_hi(s1_acc_hi),
    .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi),
    .ovf_sticky(ovf_sticky)
  );
endmodule

// File: rtl/smac_unit_chk.sv
module smac_unit_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_lo,
  input logic [DW-1:0] out_hi,
  input logic          ovf_clr,
  input logic          ovf_sticky,
  input logic          s1_valid
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi)));

  // R10
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9
  accept_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_valid);

  // R9
  stage1_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && in_ready) |=> out_valid);

  // R11
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_sticky) |-> $past(ovf_clr));

  // R11
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_sticky) |-> out_valid);
endmodule

bind smac_unit smac_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_lo(out_lo), .out_hi(out_hi),
  .ovf_clr(ovf_clr), .ovf_sticky(ovf_sticky), .s1_valid(s1_valid)
);

// File: tb/smac_unit_bench.sv
`timescale 1ns/1ps
module smac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic        in_sel_x = 1'b0;
  logic        in_sel_y = 1'b0;
  logic [31:0] in_a = '0, in_b = '0, in_acc = '0, in_acc_lo = '0, in_acc_hi = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_lo, out_hi;
  logic        ovf_clr = 1'b0;
  logic        ovf_sticky;

  always #2.5 clk = ~clk;

  smac_unit u_smac_unit (.*);

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    bit          ov;
    string       tag;
  } exp_t;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t m1, m2;
  bit   m1v = 0, m2v = 0, mflag = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t ref_calc(logic [2:0] op, bit x, bit y, logic [31:0] a,
                                    logic [31:0] b, logic [31:0] acc,
                                    logic [31:0] alo, logic [31:0] ahi);
    exp_t    e;
    shortint ha, hb;
    longint  p, w, s;
    ha = x ? a[31:16] : a[15:0];
    hb = y ? b[31:16] : b[15:0];
    p  = longint'(ha) * longint'(hb);
    w  = (longint'(int'(a)) * longint'(hb)) >>> 16;
    e.lo = '0; e.hi = '0; e.ov = 0;
    case (op)
      3'd0: begin e.lo = p[31:0]; e.tag = "R1/R2/R3"; end
      3'd1: begin
        s = p + longint'(int'(acc));
        e.lo = s[31:0]; e.ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        e.tag = "R1/R4";
      end
      3'd2: begin
        s = longint'({ahi, alo}) + p;
        e.lo = s[31:0]; e.hi = s[63:32]; e.tag = "R1/R7";
      end
      3'd3: begin e.lo = w[31:0]; e.tag = "R5"; end
      3'd4: begin
        s = w + longint'(int'(acc));
        e.lo = s[31:0]; e.ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        e.tag = "R6";
      end
      default: e.tag = "R8";
    endcase
    return e;
  endfunction

  // One clock: model advance at the edge, compare at the following falling edge.
  task automatic step();
    bit   adv, fire, set;
    exp_t e;
    adv  = !m2v || out_ready;
    fire = in_valid && adv;
    e    = ref_calc(in_op, in_sel_x, in_sel_y, in_a, in_b, in_acc, in_acc_lo, in_acc_hi);
    @(posedge clk);
    set   = adv && m1v && m1.ov;
    mflag = (mflag && !ovf_clr) || set;
    if (adv) begin
      m2v = m1v;
      if (m1v) m2 = m1;
      m1v = fire;
      if (fire) m1 = e;
    end
    @(negedge clk);
    check(out_valid == m2v, "R9 out_valid", 32'(out_valid), 32'(m2v));
    check(in_ready == (!m2v || out_ready), "R10 in_ready", 32'(in_ready), 32'(!m2v || out_ready));
    check(ovf_sticky == mflag, {"R11 flag ", m2.tag}, 32'(ovf_sticky), 32'(mflag));
    if (m2v) begin
      check(out_lo == m2.lo, {m2.tag, " lo"}, out_lo, m2.lo);
      check(out_hi == m2.hi, {m2.tag, " hi R8"}, out_hi, m2.hi);
    end
  endtask

  function automatic logic [31:0] pick_word();
    case ($urandom_range(0, 5))
      0: return 32'h8000_8000;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_7FFF;
      3: return 32'hFFFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  task automatic drive(logic [2:0] op, bit x, bit y, logic [31:0] a, logic [31:0] b,
                       logic [31:0] acc, logic [31:0] alo, logic [31:0] ahi);
    in_valid = 1; in_op = op; in_sel_x = x; in_sel_y = y;
    in_a = a; in_b = b; in_acc = acc; in_acc_lo = alo; in_acc_hi = ahi;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 and R9: reset state
    check(out_valid == 0, "R9 reset valid", 32'(out_valid), 0);
    check(ovf_sticky == 0, "R11 reset flag", 32'(ovf_sticky), 0);
    rst_n = 1;

    // R1: every selector pair with corner halves, on every op code
    for (int op = 0; op < 8; op++) begin
      for (int xy = 0; xy < 4; xy++) begin
        drive(3'(op), xy[1], xy[0], 32'h8000_1234, 32'h8000_FFFE,
              32'h4000_0000, 32'hFFFF_FFF0, 32'h0000_0001);
        step();
        drive(3'(op), xy[1], xy[0], 32'h8000_0000, 32'h8000_8000,
              32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF);
        step();
      end
    end
    in_valid = 0; step(); step();

    // R4: 0x8000*0x8000 + 0x40000000 overflows, then clear with a colliding overflow
    drive(3'd1, 0, 0, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 0, 0);
    step();
    in_valid = 0; step(); step();
    ovf_clr = 1; step(); ovf_clr = 0;
    drive(3'd4, 1, 1, 32'h7FFF_FFFF, 32'h7FFF_0000, 32'h7FFF_FFFF, 0, 0);
    step(); in_valid = 0; ovf_clr = 1; step(); ovf_clr = 0; step(); step();

    // R10: random traffic with back-pressure and occasional clears
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) != 0)
        drive(3'($urandom_range(0, 7)), 1'($urandom()), 1'($urandom()),
              pick_word(), pick_word(), pick_word(), pick_word(), pick_word());
      else
        in_valid = 0;
      out_ready = ($urandom_range(0, 3) != 0);
      ovf_clr   = ($urandom_range(0, 15) == 0);
      step();
    end
    in_valid = 0; out_ready = 1; ovf_clr = 0;
    step(); step(); step();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule